// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for each of the two ALU operands of a five-stage in-order integer pipeline, where the operand value should come from while the consuming instruction sits in the execute stage. The choice is between the value read from the register file in decode, the result held after the execute stage, and the value about to be written back. A newer result that has not yet reached the register file is routed straight to the ALU input, so dependent instructions do not have to wait for writeback.

The decision logic looks at three things: the two source register numbers of the executing instruction, the destination register numbers of the two older instructions further down the pipe, and those instructions' register-write flags. A thin top pairs this decision logic with the two operand multiplexers, so the selection codes and the resulting ALU inputs can be observed together. The whole block is combinational. Results are visible in the same cycle that the inputs change.

Top module: `operand_forward_unit`

## Requirements
- R1: When no older in-flight instruction supplies a source register, that operand's select code is 2'b00 and the ALU input equals the register-file value.
- R2: When the instruction just past execute will write a nonzero destination equal to a source register, that operand's select code is 2'b10 and the ALU input equals the execute/memory result.
- R3: When only the instruction in writeback will write a nonzero destination equal to a source register, that operand's select code is 2'b01 and the ALU input equals the writeback value.
- R4: When both older instructions qualify for the same source register, the execute/memory result (code 2'b10) is chosen because it is the more recent one.
- R5: A destination match from a stage whose register-write flag is low never causes forwarding from that stage.
- R6: A destination of register 0 never causes forwarding, whatever the write flag. A source of register 0 therefore always takes code 2'b00.
- R7: Operand A (first source) and operand B (second source) are selected independently. Each can take a different source in the same cycle.
- R8: For the chain sub r2,r1,r3; and r4,r2,r5; or r4,r4,r2; add r9,r4,r2, each operand takes the correct source as the chain moves through execute.
- R9: A select code of 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRegA | input | REG_W | First source register number of the executing instruction |
| srcRegB | input | REG_W | Second source register number of the executing instruction |
| exMemDst | input | REG_W | Destination register of the instruction after execute |
| exMemWr | input | 1 | That instruction writes a register |
| memWbDst | input | REG_W | Destination register of the instruction in writeback |
| memWbWr | input | 1 | That instruction writes a register |
| rfDataA | input | DATA_W | Register-file value latched for operand A |
| rfDataB | input | DATA_W | Register-file value latched for operand B |
| exMemResult | input | DATA_W | Result held after the execute stage |
| memWbResult | input | DATA_W | Value being written back |
| selA | output | 2 | Source code for operand A |
| selB | output | 2 | Source code for operand B |
| aluInA | output | DATA_W | Chosen ALU input A |
| aluInB | output | DATA_W | Chosen ALU input B |

## Verification
Because the block is purely combinational, a wrong decision shows up at once. It appears on the select codes and on the ALU inputs in the same settle window as the input change, with no hidden state to carry an error forward. Each data source in the bench carries a distinct tag. As a result, a wrong multiplexer leg, a missed write-flag qualification, a forward from register 0 or an inverted priority shows up as a mismatched value, not as a coincidental equality. The sweep covers every combination of register numbers 0 to 7 and both write flags on both operands. Register 31 and the chained instruction sequence are also applied.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_WB  = 2'b01,
    SEL_MEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e selA;
    fwdSel_e selB;
  } fwdStrobes_t;

  localparam int NUM_OPS = 2;

endpackage

// File: rtl/fwd_select_ctrl.sv
module fwd_select_ctrl #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0]        srcRegA,
  input  logic [REG_W-1:0]        srcRegB,
  input  logic [REG_W-1:0]        exMemDst,
  input  logic                    exMemWr,
  input  logic [REG_W-1:0]        memWbDst,
  input  logic                    memWbWr,
  output fwd_pkg::fwdStrobes_t    strobes
);
  import fwd_pkg::*;

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic exMemLive;
  logic memWbLive;
  assign exMemLive = exMemWr && (exMemDst != ZERO_REG);
  assign memWbLive = memWbWr && (memWbDst != ZERO_REG);

  logic [REG_W-1:0] srcReg [NUM_OPS];
  fwdSel_e          opSel  [NUM_OPS];

  assign srcReg[0] = srcRegA;
  assign srcReg[1] = srcRegB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    logic memHit;
    logic wbHit;
    assign memHit = exMemLive && (exMemDst == srcReg[g]);
    assign wbHit  = memWbLive && (memWbDst == srcReg[g]);

    always_comb begin
      if (memHit)     opSel[g] = SEL_MEM;
      else if (wbHit) opSel[g] = SEL_WB;
      else            opSel[g] = SEL_RF;
    end

    always_comb begin
      // R6
      zero_src_chk: assert (opSel[g] == SEL_RF || srcReg[g] != ZERO_REG);
      // R5
      wr_flag_chk: assert (!(opSel[g] == SEL_MEM && !exMemWr) &&
                           !(opSel[g] == SEL_WB && !memWbWr));
      // R4
      newer_wins_chk: assert (!(opSel[g] == SEL_WB && exMemWr &&
                                exMemDst == srcReg[g] && exMemDst != ZERO_REG));
      // R9
      legal_code_chk: assert (opSel[g] != fwdSel_e'(2'b11));
    end
  end

  assign strobes.selA = opSel[0];
  assign strobes.selB = opSel[1];

endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
  parameter int DATA_W = 32
) (
  input  fwd_pkg::fwdStrobes_t strobes,
  input  logic [DATA_W-1:0]    rfDataA,
  input  logic [DATA_W-1:0]    rfDataB,
  input  logic [DATA_W-1:0]    exMemResult,
  input  logic [DATA_W-1:0]    memWbResult,
  output logic [DATA_W-1:0]    aluInA,
  output logic [DATA_W-1:0]    aluInB
);
  import fwd_pkg::*;

  fwdSel_e           sel   [NUM_OPS];
  logic [DATA_W-1:0] rfVal [NUM_OPS];
  logic [DATA_W-1:0] outVal[NUM_OPS];

  assign sel[0]   = strobes.selA;
  assign sel[1]   = strobes.selB;
  assign rfVal[0] = rfDataA;
  assign rfVal[1] = rfDataB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_leg
    always_comb begin
      unique case (sel[g])
        SEL_MEM: outVal[g] = exMemResult;
        SEL_WB:  outVal[g] = memWbResult;
        default: outVal[g] = rfVal[g];
      endcase
    end
  end

  assign aluInA = outVal[0];
  assign aluInB = outVal[1];

endmodule

// File: rtl/operand_forward_unit.sv
module operand_forward_unit #(
  parameter int REG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic [REG_W-1:0]  srcRegA,
  input  logic [REG_W-1:0]  srcRegB,
  input  logic [REG_W-1:0]  exMemDst,
  input  logic              exMemWr,
  input  logic [REG_W-1:0]  memWbDst,
  input  logic              memWbWr,
  input  logic [DATA_W-1:0] rfDataA,
  input  logic [DATA_W-1:0] rfDataB,
  input  logic [DATA_W-1:0] exMemResult,
  input  logic [DATA_W-1:0] memWbResult,
  output logic [1:0]        selA,
  output logic [1:0]        selB,
  output logic [DATA_W-1:0] aluInA,
  output logic [DATA_W-1:0] aluInB
);
  import fwd_pkg::*;

  fwdStrobes_t strobes;

  fwd_select_ctrl #(.REG_W(REG_W)) u_ctrl (
    .srcRegA  (srcRegA),
    .srcRegB  (srcRegB),
    .exMemDst (exMemDst),
    .exMemWr  (exMemWr),
    .memWbDst (memWbDst),
    .memWbWr  (memWbWr),
    .strobes  (strobes)
  );

  fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
    .strobes     (strobes),
    .rfDataA     (rfDataA),
    .rfDataB     (rfDataB),
    .exMemResult (exMemResult),
    .memWbResult (memWbResult),
    .aluInA      (aluInA),
    .aluInB      (aluInB)
  );

  assign selA = strobes.selA;
  assign selB = strobes.selB;

endmodule

// File: tb/sim_operand_forward_unit.sv
`timescale 1ns/1ps
module sim_operand_forward_unit;
  localparam int REG_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [REG_W-1:0]  srcRegA, srcRegB, exMemDst, memWbDst;
  logic              exMemWr, memWbWr;
  logic [DATA_W-1:0] rfDataA, rfDataB, exMemResult, memWbResult;
  logic [1:0]        selA, selB;
  logic [DATA_W-1:0] aluInA, aluInB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  operand_forward_unit #(.REG_W(REG_W), .DATA_W(DATA_W)) u0 (
    .srcRegA(srcRegA), .srcRegB(srcRegB),
    .exMemDst(exMemDst), .exMemWr(exMemWr),
    .memWbDst(memWbDst), .memWbWr(memWbWr),
    .rfDataA(rfDataA), .rfDataB(rfDataB),
    .exMemResult(exMemResult), .memWbResult(memWbResult),
    .selA(selA), .selB(selB), .aluInA(aluInA), .aluInB(aluInB)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] got,
                     input logic [DATA_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // expected code from the requirement text: 2'b10 newer stage, 2'b01 writeback, 2'b00 file
  function automatic logic [1:0] expCode(input logic [REG_W-1:0] s,
      input logic [REG_W-1:0] ed, input logic ew,
      input logic [REG_W-1:0] wd, input logic ww);
    if (ew && ed != 0 && ed == s) return 2'b10;
    if (ww && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string tagOf(input logic [REG_W-1:0] s,
      input logic [REG_W-1:0] ed, input logic ew,
      input logic [REG_W-1:0] wd, input logic ww);
    logic [1:0] c;
    c = expCode(s, ed, ew, wd, ww);
    if (c == 2'b10 && ww && wd == s) return "R4";
    if (c == 2'b10) return "R2";
    if (c == 2'b01) return "R3";
    if (s == 0 && (ed == 0 || wd == 0)) return "R6";
    if (ed == s || wd == s) return "R5";
    return "R1";
  endfunction

  task automatic apply(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b,
      input logic [REG_W-1:0] ed, input logic ew,
      input logic [REG_W-1:0] wd, input logic ww);
    srcRegA = a; srcRegB = b;
    exMemDst = ed; exMemWr = ew;
    memWbDst = wd; memWbWr = ww;
    #1;
  endtask

  function automatic logic [DATA_W-1:0] pick(input logic [1:0] c,
      input logic [DATA_W-1:0] rf);
    case (c)
      2'b10:   return exMemResult;
      2'b01:   return memWbResult;
      default: return rf;
    endcase
  endfunction

  task automatic sweepCheck();
    logic [1:0] ea, eb;
    ea = expCode(srcRegA, exMemDst, exMemWr, memWbDst, memWbWr);
    eb = expCode(srcRegB, exMemDst, exMemWr, memWbDst, memWbWr);
    chk({tagOf(srcRegA, exMemDst, exMemWr, memWbDst, memWbWr), " selA"}, 32'(selA), 32'(ea));
    chk({tagOf(srcRegB, exMemDst, exMemWr, memWbDst, memWbWr), " selB"}, 32'(selB), 32'(eb));
    chk("aluInA", aluInA, pick(ea, rfDataA));
    chk("aluInB", aluInB, pick(eb, rfDataB));
    if (selA == 2'b11 || selB == 2'b11) begin
      total++; bad++;
      $display("FAIL R9 got=%b/%b exp=not 11", selA, selB);
    end
  endtask

  initial begin
    rfDataA = 32'hAAAA_0001; rfDataB = 32'hBBBB_0002;
    exMemResult = 32'hEEEE_0003; memWbResult = 32'hDDDD_0004;
    apply('0, '0, '0, 1'b0, '0, 1'b0);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 idle state
    chk("R1 idle selA", 32'(selA), 32'd0);
    chk("R1 idle aluInA", aluInA, rfDataA);
    chk("R1 idle aluInB", aluInB, rfDataB);

    // exhaustive sweep over registers 0..7 and both flags
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int ed = 0; ed < 8; ed++)
          for (int wd = 0; wd < 8; wd++)
            for (int f = 0; f < 4; f++) begin
              rfDataA = 32'hA000_0000 | (a << 8) | ed;
              rfDataB = 32'hB000_0000 | (b << 8) | wd;
              apply(REG_W'(a), REG_W'(b), REG_W'(ed), f[0], REG_W'(wd), f[1]);
              sweepCheck();
            end

    // top register number
    apply(5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b1);
    chk("R4 r31 selA", 32'(selA), 32'd2);
    apply(5'd31, 5'd30, 5'd30, 1'b1, 5'd31, 1'b1);
    chk("R3 r31 selA", 32'(selA), 32'd1);
    chk("R2 r30 selB", 32'(selB), 32'd2);

    // R7 independent operands: A from newer stage, B from writeback
    apply(5'd6, 5'd7, 5'd6, 1'b1, 5'd7, 1'b1);
    chk("R7 selA", 32'(selA), 32'd2);
    chk("R7 selB", 32'(selB), 32'd1);
    chk("R7 aluInA", aluInA, exMemResult);
    chk("R7 aluInB", aluInB, memWbResult);

    // R6 zero destination with write asserted
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R6 selA", 32'(selA), 32'd0);
    chk("R6 aluInB", aluInB, rfDataB);

    // R8 chain: and r4,r2,r5 in execute, sub (r2) ahead
    apply(5'd2, 5'd5, 5'd2, 1'b1, 5'd0, 1'b0);
    chk("R8 and selA", 32'(selA), 32'd2);
    chk("R8 and selB", 32'(selB), 32'd0);
    // or r4,r4,r2: and (r4) ahead, sub (r2) in writeback
    apply(5'd4, 5'd2, 5'd4, 1'b1, 5'd2, 1'b1);
    chk("R8 or selA", 32'(selA), 32'd2);
    chk("R8 or selB", 32'(selB), 32'd1);
    chk("R8 or aluInB", aluInB, memWbResult);
    // add r9,r4,r2: or (r4) ahead, and (r4) in writeback; r2 from file
    apply(5'd4, 5'd2, 5'd4, 1'b1, 5'd4, 1'b1);
    chk("R8 add selA", 32'(selA), 32'd2);
    chk("R8 add aluInA", aluInA, exMemResult);
    chk("R8 add selB", 32'(selB), 32'd0);
    chk("R8 add aluInB", aluInB, rfDataB);

    @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule